// File: doc/BRIEF.md
# Per-Core Debug Break Controller

This block sits beside one processor core and decides, instruction by instruction, whether the core must divert into its debug interrupt. It watches the program counter, the execution context (the main program or one of three interrupt levels), a launch strobe, break requests arriving from other cores, and a strobe that marks the end of the debug handler. When a break is due, it raises a one-cycle request toward the core's interrupt logic. Alongside the request it presents the shared-memory address of that core's debug vector, and a status field naming every source that fired.

Every launch arms a start-up break, so a freshly started core traps before its first instruction with no change to the program. If the vector slot holds only a return-from-debug, the core then runs at full speed, because launch clears all step, breakpoint and cross-core enables. A debug handler that wants more control writes the control register while it runs. That register selects single-step per context, an address breakpoint with its compare address, and whether requests from other cores are accepted. While the handler runs, no new break is taken. The return strobe re-arms the sources.

Top module: `dbg_break_ctrl`

## Requirements
- R1: `brk_vec` equals 0x400 + 4 × `core_id` (20-bit byte address), following `core_id` one cycle later.
- R2: After a `launch` pulse, the next cycle with `insn_valid` high raises `brk_req` with `brk_cause` = 4'b0001 (bit0 start-up, bit1 single-step, bit2 breakpoint, bit3 cross-core).
- R3: `brk_req` is high for exactly one cycle per break, in the cycle after the triggering `insn_valid` cycle.
- R4: After reset, `brk_req`, `in_debug` and `brk_cause` are zero, and `insn_valid` causes no break until a launch.
- R5: Launch clears all enables. After the first break, a bare `dbg_return` lets instructions run with no further break.
- R6: While `in_debug` is high, no break is taken and `async_req` pulses are discarded. `dbg_return` clears `in_debug` one cycle later.
- R7: Control flag bits [3:0] enable single-step for context 0 (main) to 3 (interrupt levels 1..3). A break fires only for an instruction issued in an enabled context.
- R8: Control flag bit 4 enables the breakpoint, which fires when `pc` equals the programmed `ctl_addr`. It is disabled after reset and after launch.
- R9: `ctl_we` is ignored while `in_debug` is low.
- R10: With control flag bit 5 set, an `async_req` pulse outside debug is held until the next valid instruction, which then breaks with cause bit3.
- R11: Sources firing in the same cycle give one break, with `brk_cause` holding every one of them.
- R12: `launch` while in debug leaves debug mode and re-arms the start-up break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_id | input | 4 | Number of this core |
| launch | input | 1 | Core start strobe |
| insn_valid | input | 1 | An instruction at `pc` is about to issue |
| pc | input | 20 | Program counter of that instruction |
| ctx | input | 2 | Context: 0 main, 1..3 interrupt level |
| async_req | input | 1 | Break request from another core |
| ctl_we | input | 1 | Control write strobe (handler only) |
| ctl_flags | input | 6 | [3:0] step per context, [4] breakpoint on, [5] cross-core on |
| ctl_addr | input | 20 | Breakpoint compare address |
| dbg_return | input | 1 | Debug handler finished |
| brk_req | output | 1 | Debug interrupt request pulse |
| brk_cause | output | 4 | Sources of the last break |
| brk_vec | output | 20 | Debug vector address |
| in_debug | output | 1 | Debug handler active |

## Verification
The break decision is driven with single sources in isolation and with all three run-time sources in one cycle. A single-source break that reports the wrong bit is thus distinguished from a combined break that drops a cause. Single-step is enabled for one context and stepped through all four, which separates a correct context decode from one that is off by one level or ignores the level. The breakpoint is probed one address below the programmed value and then at it, and cross-core requests are sent both outside and inside debug mode. Together these show whether the sources are gated by debug state and whether the compare is exact.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int NCTX  = 4;
  localparam int CTX_W = $clog2(NCTX);

  typedef struct packed {
    logic            xcore_en;
    logic            bp_en;
    logic [NCTX-1:0] step_en;
  } ctl_t;

  typedef struct packed {
    logic xcore;
    logic bpoint;
    logic step;
    logic start;
  } cause_t;
endpackage

// File: rtl/dbg_src_eval.sv
module dbg_src_eval
  import dbg_brk_pkg::*;
#(
  parameter int PC_W = 20
) (
  input  ctl_t             ctl,
  input  logic [PC_W-1:0]  bp_addr,
  input  logic [PC_W-1:0]  pc,
  input  logic [CTX_W-1:0] ctx,
  input  logic             start_pend,
  input  logic             xcore_pend,
  input  logic             async_req,
  output cause_t           cause
);
  logic [NCTX-1:0] lvl_hit;

  for (genvar i = 0; i < NCTX; i++) begin : g_lvl
    assign lvl_hit[i] = ctl.step_en[i] && (ctx == CTX_W'(i));
  end

  always_comb begin
    cause.start  = start_pend;
    cause.step   = |lvl_hit;
    cause.bpoint = ctl.bp_en && (pc == bp_addr);
    cause.xcore  = xcore_pend || (async_req && ctl.xcore_en);
  end
endmodule

// File: rtl/dbg_vec_gen.sv
module dbg_vec_gen #(
  parameter int          CID_W      = 4,
  parameter int          ADDR_W     = 20,
  parameter logic [31:0] VEC_BASE   = 32'h400,
  parameter int          SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic [CID_W-1:0]  core_id,
  output logic [ADDR_W-1:0] brk_vec
);
  localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

  always_ff @(posedge clk) begin
    brk_vec <= ADDR_W'(VEC_BASE) + (ADDR_W'(core_id) << SLOT_SHIFT);
  end
endmodule

// File: rtl/dbg_brk_state.sv
module dbg_brk_state
  import dbg_brk_pkg::*;
#(
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic            insn_valid,
  input  logic            async_req,
  input  logic            ctl_we,
  input  ctl_t            ctl_in,
  input  logic [PC_W-1:0] ctl_addr,
  input  logic            dbg_return,
  input  cause_t          cause,
  output ctl_t            ctl,
  output logic [PC_W-1:0] bp_addr,
  output logic            start_pend,
  output logic            xcore_pend,
  output logic            brk_req,
  output cause_t          brk_cause,
  output logic            in_debug
);
  logic take;
  assign take = !in_debug && insn_valid && (|cause);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl        <= '0;
      bp_addr    <= '0;
      start_pend <= 1'b0;
      xcore_pend <= 1'b0;
      brk_req    <= 1'b0;
      brk_cause  <= '0;
      in_debug   <= 1'b0;
    end else if (launch) begin
      ctl        <= '0;
      bp_addr    <= '0;
      start_pend <= 1'b1;
      xcore_pend <= 1'b0;
      brk_req    <= 1'b0;
      in_debug   <= 1'b0;
    end else begin
      brk_req <= take;
      if (take) begin
        brk_cause  <= cause;
        in_debug   <= 1'b1;
        start_pend <= 1'b0;
        xcore_pend <= 1'b0;
      end else if (!in_debug && async_req && ctl.xcore_en) begin
        xcore_pend <= 1'b1;
      end
      if (in_debug) begin
        if (ctl_we) begin
          ctl     <= ctl_in;
          bp_addr <= ctl_addr;
        end
        if (dbg_return) in_debug <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
  import dbg_brk_pkg::*;
#(
  parameter int          CID_W      = 4,
  parameter int          PC_W       = 20,
  parameter int          ADDR_W     = 20,
  parameter logic [31:0] VEC_BASE   = 32'h400,
  parameter int          SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CID_W-1:0]  core_id,
  input  logic              launch,
  input  logic              insn_valid,
  input  logic [PC_W-1:0]   pc,
  input  logic [CTX_W-1:0]  ctx,
  input  logic              async_req,
  input  logic              ctl_we,
  input  logic [5:0]        ctl_flags,
  input  logic [PC_W-1:0]   ctl_addr,
  input  logic              dbg_return,
  output logic              brk_req,
  output logic [3:0]        brk_cause,
  output logic [ADDR_W-1:0] brk_vec,
  output logic              in_debug
);
  ctl_t            ctl_q;
  logic [PC_W-1:0] bp_addr;
  logic            start_pend, xcore_pend;
  cause_t          cause, cause_q;

  dbg_src_eval #(.PC_W(PC_W)) u_eval (
    .ctl(ctl_q), .bp_addr(bp_addr), .pc(pc), .ctx(ctx),
    .start_pend(start_pend), .xcore_pend(xcore_pend),
    .async_req(async_req), .cause(cause)
  );

  dbg_brk_state #(.PC_W(PC_W)) u_state (
    .clk(clk), .rst(rst), .launch(launch), .insn_valid(insn_valid),
    .async_req(async_req), .ctl_we(ctl_we), .ctl_in(ctl_t'(ctl_flags)),
    .ctl_addr(ctl_addr), .dbg_return(dbg_return), .cause(cause),
    .ctl(ctl_q), .bp_addr(bp_addr), .start_pend(start_pend),
    .xcore_pend(xcore_pend), .brk_req(brk_req), .brk_cause(cause_q),
    .in_debug(in_debug)
  );

  dbg_vec_gen #(
    .CID_W(CID_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .SLOT_BYTES(SLOT_BYTES)
  ) u_vec (
    .clk(clk), .core_id(core_id), .brk_vec(brk_vec)
  );

  assign brk_cause = cause_q;
endmodule

// File: rtl/dbg_break_ctrl_chk.sv
module dbg_break_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              launch,
  input logic              insn_valid,
  input logic              dbg_return,
  input logic              brk_req,
  input logic [3:0]        brk_cause,
  input logic [ADDR_W-1:0] brk_vec,
  input logic              in_debug
);
  // R3
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req);
  // R3: a break needs an issuing instruction one cycle earlier
  a_r3_after_insn: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> !brk_req);
  // R6
  a_r6_quiet_in_debug: assert property (@(posedge clk) disable iff (rst)
    in_debug |=> !brk_req);
  // R6
  a_r6_return_exits: assert property (@(posedge clk) disable iff (rst)
    (in_debug && dbg_return) |=> !in_debug);
  // R11: a break always names at least one source
  a_r11_cause_present: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (brk_cause != 4'b0000));
  // R2
  a_r2_enters_debug: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> in_debug);
  // R1: vector lies on a slot boundary
  a_r1_vec_aligned: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (brk_vec[1:0] == 2'b00));
  // R12
  a_r12_launch_leaves: assert property (@(posedge clk) disable iff (rst)
    launch |=> (!in_debug && !brk_req));
endmodule

bind dbg_break_ctrl dbg_break_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .launch(launch), .insn_valid(insn_valid),
  .dbg_return(dbg_return), .brk_req(brk_req), .brk_cause(brk_cause),
  .brk_vec(brk_vec), .in_debug(in_debug)
);

// File: tb/tb_dbg_break_ctrl.sv
module tb_dbg_break_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  core_id;
  logic        launch, insn_valid, async_req, ctl_we, dbg_return;
  logic [19:0] pc, ctl_addr, brk_vec;
  logic [1:0]  ctx;
  logic [5:0]  ctl_flags;
  logic        brk_req, in_debug;
  logic [3:0]  brk_cause;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #2 clk = ~clk;

  dbg_break_ctrl dut (
    .clk(clk), .rst(rst), .core_id(core_id), .launch(launch),
    .insn_valid(insn_valid), .pc(pc), .ctx(ctx), .async_req(async_req),
    .ctl_we(ctl_we), .ctl_flags(ctl_flags), .ctl_addr(ctl_addr),
    .dbg_return(dbg_return), .brk_req(brk_req), .brk_cause(brk_cause),
    .brk_vec(brk_vec), .in_debug(in_debug)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic insn(logic [19:0] a, logic [1:0] c);
    pc = a; ctx = c; insn_valid = 1'b1;
    tick();
    insn_valid = 1'b0;
  endtask

  task automatic do_launch();
    launch = 1'b1; tick(); launch = 1'b0;
  endtask

  task automatic wr_ctl(logic [5:0] f, logic [19:0] a);
    ctl_flags = f; ctl_addr = a; ctl_we = 1'b1; tick(); ctl_we = 1'b0;
  endtask

  task automatic do_return();
    dbg_return = 1'b1; tick(); dbg_return = 1'b0;
  endtask

  task automatic enter_debug();
    do_launch();
    insn(20'h0, 2'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
    check("R4 brk_req", brk_req, 0);
    check("R4 in_debug", in_debug, 0);
    check("R4 cause", brk_cause, 0);
    check("R1 vec id0", brk_vec, 20'h400);
    insn(20'h10, 2'd0);
    check("R4 no break before launch", brk_req, 0);
  endtask

  task automatic t_startup();
    do_launch();
    check("R12 no break on launch", brk_req, 0);
    insn(20'h0, 2'd0);
    check("R2 start break", brk_req, 1);
    check("R2 start cause", brk_cause, 4'b0001);
    check("R2 in_debug", in_debug, 1);
    insn(20'h4, 2'd0);
    check("R3 pulse ends", brk_req, 0);
    check("R6 no break in debug", brk_req, 0);
  endtask

  task automatic t_free_run();
    do_return();
    check("R6 return clears", in_debug, 0);
    for (int i = 0; i < 4; i++) begin
      insn(20'(i * 4), 2'(i));
      check("R5 free run", brk_req, 0);
    end
  endtask

  task automatic t_ignore_write();
    wr_ctl(6'b00_0001, 20'h0);
    insn(20'h20, 2'd0);
    check("R9 write outside debug ignored", brk_req, 0);
  endtask

  task automatic t_step_ctx();
    enter_debug();
    wr_ctl(6'b00_0100, 20'h0);
    do_return();
    for (int c = 0; c < 4; c++) begin
      insn(20'h100 + 20'(c), 2'(c));
      if (c == 2) begin
        check("R7 step break ctx2", brk_req, 1);
        check("R7 step cause", brk_cause, 4'b0010);
        do_return();
      end else begin
        check("R7 no step other ctx", brk_req, 0);
      end
    end
  endtask

  task automatic t_bkpt();
    enter_debug();
    wr_ctl(6'b01_0000, 20'h123);
    do_return();
    insn(20'h122, 2'd0);
    check("R8 miss below", brk_req, 0);
    insn(20'h123, 2'd1);
    check("R8 hit", brk_req, 1);
    check("R8 cause", brk_cause, 4'b0100);
  endtask

  task automatic t_async();
    enter_debug();
    wr_ctl(6'b10_0000, 20'h0);
    async_req = 1'b1; tick(); async_req = 1'b0;
    do_return();
    insn(20'h40, 2'd0);
    check("R6 async in debug dropped", brk_req, 0);
    async_req = 1'b1; tick(); async_req = 1'b0;
    tick();
    check("R10 no break without insn", brk_req, 0);
    insn(20'h44, 2'd3);
    check("R10 held async break", brk_req, 1);
    check("R10 cause", brk_cause, 4'b1000);
  endtask

  task automatic t_multi();
    enter_debug();
    wr_ctl(6'b11_0001, 20'h200);
    do_return();
    async_req = 1'b1;
    insn(20'h200, 2'd0);
    async_req = 1'b0;
    check("R11 one break", brk_req, 1);
    check("R11 all causes", brk_cause, 4'b1110);
    tick();
    check("R3 single pulse", brk_req, 0);
  endtask

  task automatic t_relaunch();
    enter_debug();
    wr_ctl(6'b11_0001, 20'h0);
    do_launch();
    check("R12 launch leaves debug", in_debug, 0);
    insn(20'h0, 2'd0);
    check("R12 start only", brk_cause, 4'b0001);
    do_return();
    insn(20'h0, 2'd0);
    check("R5 enables cleared", brk_req, 0);
  endtask

  task automatic t_vector();
    core_id = 4'd5; tick();
    check("R1 vec id5", brk_vec, 20'h414);
    core_id = 4'd15; tick();
    check("R1 vec id15", brk_vec, 20'h43C);
  endtask

  initial begin
    rst = 1'b1; core_id = '0; launch = 0; insn_valid = 0; async_req = 0;
    ctl_we = 0; dbg_return = 0; pc = '0; ctx = '0; ctl_flags = '0; ctl_addr = '0;
    tick();
    t_reset();
    t_startup();
    t_free_run();
    t_ignore_write();
    t_step_ctx();
    t_bkpt();
    t_async();
    t_multi();
    t_relaunch();
    t_vector();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule